// File: doc/BRIEF.md
# Adapter error interrupt request controller

This block raises and retires the error interrupt of a bus adapter that bridges a host interconnect to a downstream device bus. When a host-side access times out, the block records the first failing address and, if error interrupts are enabled, marks an interrupt source. The request is presented on a set of per-level request lines chosen by a level mask. Requests from downstream devices are merged onto the same lines. When the host acknowledges an interrupt at some level, the block answers with a vector.

An accepted acknowledge does not clear the source. It sets a "done" flag that masks the request until software removes the source. Software then reads and writes four small registers through a simple write/read port: adapter control, error status, interrupt control and downstream vector offset. A fifth, read-only view holds the failing address. The request lines and the acknowledge answer are registered. Each takes effect at the clock edge after the causing event.

Top module: `err_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is zero and `ack_resp` is low.
- R2: When `err_event` is high and the fail flag (ACTL bit 8) is clear, the fail flag is set and `err_addr` is captured in FADDR. Only if ACTL bit 0 (error interrupt enable) is then set does the event also set the internal flag (ACTL bit 9, read-only) and the force bit (ICTL bit 31). Every event sets ESTAT bit 0.
- R3: While the fail flag stays set, further events leave FADDR unchanged.
- R4: A request is pending when the internal flag or the force bit is set, and ACTL bit 1 (hard enable) or bit 2 (soft enable) is set, and the done bit (ICTL bit 30) is clear. While a request is pending, `irq` equals the level mask (ICTL bits 16 and up, one bit per level). Otherwise the adapter drives no line. `irq` follows at the next clock edge.
- R5: A `dev_req` bit sets the same `irq` bit at the next clock edge, whatever the adapter request.
- R6: An acknowledge whose level bit is set in the mask while a request is pending returns the ICTL vector field (bits 13:0) and sets the done bit. Any other acknowledge returns the VOFF vector (bits 13:0). The answer appears on `ack_vec` with `ack_resp` high one cycle after `ack_valid`.
- R7: A write to ICTL (sel 2) loads the vector, the mask and the force bit, and clears the done bit where bit 30 is written one. If the force bit is then clear, the internal flag and the done bit are both cleared.
- R8: A write to ACTL (sel 0; bits 2:0 read/write, bit 8 write-one-to-clear) or to ESTAT (sel 1; bit 0 write-one-to-clear) then clears the internal flag if the enable bit is clear, and clears the done bit if no source is left.
- R9: In a cycle with both a register write and an acknowledge, the acknowledge sees the state after the write.
- R10: Clearing the fail flag by writing ACTL bit 8 as one lets the next event capture a new address and raise the interrupt again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 ACTL, 1 ESTAT, 2 ICTL, 3 VOFF |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Read target: 0 ACTL, 1 ESTAT, 2 ICTL, 3 VOFF, 4 FADDR |
| rd_data | output | 32 | Combinational read data |
| err_event | input | 1 | Host-side timeout or non-existent access pulse |
| err_addr | input | AW | Address of the failing access |
| dev_req | input | NL | Downstream device requests, one per level |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_level | input | LW | Level being acknowledged |
| ack_resp | output | 1 | Acknowledge answer valid |
| ack_vec | output | 14 | Vector returned for the acknowledge |
| irq | output | NL | Per-level interrupt request lines |

## Verification
Assertions check these rules on every cycle:
- The internal flag never stands without the force bit.
- A write that clears the force bit leaves no source and no done bit.
- The captured address stays fixed while the fail flag holds.
- An accepted acknowledge always sets the done bit and returns the control vector.
- `irq` always covers the previous cycle's downstream requests.
- With no pending request, no other line is raised.

Other behaviour can only be shown by the bench's scenarios:
- The gating by the enable bits, including the soft-enable path.
- The choice between the two vector sources by level.
- Write-before-acknowledge ordering in one cycle.
- Re-arming after the fail flag is cleared.
- An event with interrupts disabled, which records the failure but raises no request.

// File: rtl/err_irq_pkg.sv
// Package: shared definitions of the adapter error interrupt controller.
// Assumes the register select codes below are fixed by the software map.
package err_irq_pkg;
    localparam int VEC_W = 14;

    typedef enum logic [2:0] {
        SEL_ACTL  = 3'd0,
        SEL_ESTAT = 3'd1,
        SEL_ICTL  = 3'd2,
        SEL_VOFF  = 3'd3,
        SEL_FADDR = 3'd4
    } reg_sel_e;

    // ACTL bit positions
    localparam int ACTL_EIE  = 0;
    localparam int ACTL_HARD = 1;
    localparam int ACTL_SOFT = 2;
    localparam int ACTL_FAIL = 8;
    localparam int ACTL_FLAG = 9;
    // ICTL bit positions
    localparam int ICTL_MASK = 16;
    localparam int ICTL_DONE = 30;
    localparam int ICTL_FRC  = 31;
endpackage

// File: rtl/eirq_regs.sv
// eirq_regs: register state of the error interrupt controller.
// The next state is built in two stages. Stage one applies a register write
// and then an error event; the acknowledge decision is taken from it.
// Stage two adds the done bit of an accepted acknowledge.
// Assumes NL <= 14 and AW <= 32.
module eirq_regs
    import err_irq_pkg::*;
#(
    parameter int NL = 4,
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             err_event,
    input  logic [AW-1:0]    err_addr,
    input  logic             ack_hit,
    output logic             s1_req,
    output logic [NL-1:0]    s1_mask,
    output logic [VEC_W-1:0] s1_vec,
    output logic [VEC_W-1:0] voff_q,
    output logic             req_n,
    output logic [31:0]      actl_rd,
    output logic [31:0]      estat_rd,
    output logic [31:0]      ictl_rd,
    output logic [31:0]      faddr_rd
);
    logic eie_q, hard_q, soft_q, fail_q, flag_q, frc_q, done_q, est_q;
    logic [AW-1:0]    faddr_q;
    logic [VEC_W-1:0] vec_q;
    logic [NL-1:0]    mask_q;

    logic eie1, hard1, soft1, fail1, flag1, frc1, done1, est1, chk1;
    logic [AW-1:0]    faddr1;
    logic [VEC_W-1:0] voff1;
    logic             unused_wdata;
    reg_sel_e         sel;

    assign sel          = reg_sel_e'(wr_sel);
    assign unused_wdata = ^wr_data;

    // Stage one: apply write, then clear check, then error event.
    always_comb begin
        eie1 = eie_q; hard1 = hard_q; soft1 = soft_q; fail1 = fail_q;
        flag1 = flag_q; frc1 = frc_q; done1 = done_q; est1 = est_q;
        faddr1 = faddr_q; s1_vec = vec_q; s1_mask = mask_q; voff1 = voff_q;
        chk1 = 1'b0;
        if (wr_en) begin
            case (sel)
                SEL_ACTL: begin
                    eie1  = wr_data[ACTL_EIE];
                    hard1 = wr_data[ACTL_HARD];
                    soft1 = wr_data[ACTL_SOFT];
                    fail1 = fail_q & ~wr_data[ACTL_FAIL];
                    chk1  = 1'b1;
                end
                SEL_ESTAT: begin
                    est1 = est_q & ~wr_data[0];
                    chk1 = 1'b1;
                end
                SEL_ICTL: begin
                    s1_vec  = wr_data[VEC_W-1:0];
                    s1_mask = wr_data[ICTL_MASK +: NL];
                    frc1    = wr_data[ICTL_FRC];
                    done1   = done_q & ~wr_data[ICTL_DONE];
                    if (!frc1) begin
                        flag1 = 1'b0;
                        done1 = 1'b0;
                    end
                end
                SEL_VOFF: voff1 = wr_data[VEC_W-1:0];
                default: ;
            endcase
        end
        if (chk1) begin
            if (!eie1) flag1 = 1'b0;
            if (!(flag1 || frc1)) done1 = 1'b0;
        end
        if (err_event) begin
            est1 = 1'b1;
            if (!fail1) begin
                fail1  = 1'b1;
                faddr1 = err_addr;
                if (eie1) begin
                    flag1 = 1'b1;
                    frc1  = 1'b1;
                end
            end
        end
        s1_req = (flag1 || frc1) && (hard1 || soft1) && !done1;
    end

    // Stage two: an accepted acknowledge masks the request from now on.
    assign req_n = s1_req && !ack_hit;

    // State update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eie_q <= 1'b0; hard_q <= 1'b0; soft_q <= 1'b0; fail_q <= 1'b0;
            flag_q <= 1'b0; frc_q <= 1'b0; done_q <= 1'b0; est_q <= 1'b0;
            faddr_q <= '0; vec_q <= '0; mask_q <= '0; voff_q <= '0;
        end else begin
            eie_q <= eie1; hard_q <= hard1; soft_q <= soft1; fail_q <= fail1;
            flag_q <= flag1; frc_q <= frc1; done_q <= done1 || ack_hit;
            est_q <= est1; faddr_q <= faddr1; vec_q <= s1_vec;
            mask_q <= s1_mask; voff_q <= voff1;
        end
    end

    // Read views of the register state.
    always_comb begin
        actl_rd = '0;
        actl_rd[ACTL_EIE]  = eie_q;
        actl_rd[ACTL_HARD] = hard_q;
        actl_rd[ACTL_SOFT] = soft_q;
        actl_rd[ACTL_FAIL] = fail_q;
        actl_rd[ACTL_FLAG] = flag_q;
        estat_rd    = '0;
        estat_rd[0] = est_q;
        ictl_rd = '0;
        ictl_rd[VEC_W-1:0]       = vec_q;
        ictl_rd[ICTL_MASK +: NL] = mask_q;
        ictl_rd[ICTL_DONE]       = done_q;
        ictl_rd[ICTL_FRC]        = frc_q;
        faddr_rd = '0;
        faddr_rd[AW-1:0] = faddr_q;
    end

    // R7
    // flag_implies_force_chk: the internal flag never stands without force.
    flag_implies_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |-> frc_q);

    // R7
    // force_clear_chk: a force-clearing control write leaves no source or done.
    force_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_ICTL && !wr_data[ICTL_FRC] && !err_event)
        |=> (!frc_q && !flag_q && !done_q));

    // R3
    // first_addr_held_chk: the captured address is stable while fail stays set.
    first_addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !(wr_en && sel == SEL_ACTL && wr_data[ACTL_FAIL]))
        |=> $stable(faddr_q));

    // R6
    // ack_sets_done_chk: an accepted acknowledge leaves done set.
    ack_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> done_q);
endmodule

// File: rtl/eirq_ack.sv
// eirq_ack: answers an interrupt acknowledge with a vector.
// It uses the stage-one state, so a write in the same cycle is already seen.
// Assumes ack_level addresses one of the NL levels; higher values never hit.
module eirq_ack
    import err_irq_pkg::*;
#(
    parameter int NL = 4,
    parameter int LW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_valid,
    input  logic [LW-1:0]    ack_level,
    input  logic             s1_req,
    input  logic [NL-1:0]    s1_mask,
    input  logic [VEC_W-1:0] s1_vec,
    input  logic [VEC_W-1:0] voff_q,
    output logic             ack_hit,
    output logic             ack_resp_q,
    output logic [VEC_W-1:0] ack_vec_q
);
    logic [NL-1:0] lvl_onehot;

    // Decide whether the acknowledge belongs to the adapter's own request.
    always_comb begin
        lvl_onehot = NL'(1) << ack_level;
        ack_hit    = ack_valid && s1_req && ((s1_mask & lvl_onehot) != '0);
    end

    // Register the answer: control vector on a hit, offset vector otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_resp_q <= 1'b0;
            ack_vec_q  <= '0;
        end else begin
            ack_resp_q <= ack_valid;
            if (ack_valid) ack_vec_q <= ack_hit ? s1_vec : voff_q;
        end
    end

    // R6
    // hit_vector_chk: an accepted acknowledge answers with the control vector.
    hit_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> (ack_resp_q && ack_vec_q == $past(s1_vec)));

    // R6
    // miss_vector_chk: any other acknowledge answers with the offset vector.
    miss_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ack_hit) |=> (ack_resp_q && ack_vec_q == $past(voff_q)));
endmodule

// File: rtl/eirq_lines.sv
// eirq_lines: registered per-level request lines.
// Each line is the adapter request gated by its mask bit, OR the downstream
// request of the same level. Assumes req_n and mask_n are next-state values.
module eirq_lines #(
    parameter int NL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_n,
    input  logic [NL-1:0] mask_n,
    input  logic [NL-1:0] dev_req,
    output logic [NL-1:0] irq_q
);
    logic valid_q;

    // Mark the first cycle after reset so that the checks see real history.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= 1'b1;
    end

    for (genvar i = 0; i < NL; i++) begin : g_level
        // One flop per level: adapter request or downstream request.
        always_ff @(posedge clk) begin
            if (!rst_n) irq_q[i] <= 1'b0;
            else        irq_q[i] <= (req_n && mask_n[i]) || dev_req[i];
        end
    end

    // R5
    // dev_merge_chk: every downstream request shows on its line.
    dev_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ((irq_q & $past(dev_req)) == $past(dev_req)));

    // R4
    // idle_lines_chk: with no adapter request only downstream lines are up.
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !$past(req_n)) |-> ((irq_q & ~$past(dev_req)) == '0));
endmodule

// File: rtl/err_irq_ctrl.sv
// err_irq_ctrl: adapter error interrupt request controller (top).
// Connects the register state, the acknowledge responder and the request
// lines, and selects the read view. Assumes NL <= 14 and AW <= 32.
module err_irq_ctrl
    import err_irq_pkg::*;
#(
    parameter int NL = 4,
    parameter int AW = 32,
    parameter int LW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic [2:0]       rd_sel,
    output logic [31:0]      rd_data,
    input  logic             err_event,
    input  logic [AW-1:0]    err_addr,
    input  logic [NL-1:0]    dev_req,
    input  logic             ack_valid,
    input  logic [LW-1:0]    ack_level,
    output logic             ack_resp,
    output logic [VEC_W-1:0] ack_vec,
    output logic [NL-1:0]    irq
);
    logic             s1_req, req_n, ack_hit;
    logic [NL-1:0]    s1_mask;
    logic [VEC_W-1:0] s1_vec, voff_q;
    logic [31:0]      actl_rd, estat_rd, ictl_rd, faddr_rd;

    eirq_regs #(.NL(NL), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .err_event(err_event), .err_addr(err_addr),
        .ack_hit(ack_hit), .s1_req(s1_req), .s1_mask(s1_mask),
        .s1_vec(s1_vec), .voff_q(voff_q), .req_n(req_n),
        .actl_rd(actl_rd), .estat_rd(estat_rd), .ictl_rd(ictl_rd),
        .faddr_rd(faddr_rd)
    );

    eirq_ack #(.NL(NL), .LW(LW)) u_ack (
        .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid),
        .ack_level(ack_level), .s1_req(s1_req), .s1_mask(s1_mask),
        .s1_vec(s1_vec), .voff_q(voff_q), .ack_hit(ack_hit),
        .ack_resp_q(ack_resp), .ack_vec_q(ack_vec)
    );

    eirq_lines #(.NL(NL)) u_lines (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .mask_n(s1_mask),
        .dev_req(dev_req), .irq_q(irq)
    );

    // Read view select.
    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_ACTL:  rd_data = actl_rd;
            SEL_ESTAT: rd_data = estat_rd;
            SEL_ICTL:  rd_data = ictl_rd;
            SEL_VOFF:  rd_data = 32'(voff_q);
            SEL_FADDR: rd_data = faddr_rd;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: tb/err_irq_ctrl_bench.sv
// Scoreboard bench: driver tasks push expected items, the monitor pops and
// compares them at the falling edge.
module err_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        err_event = 1'b0;
    logic [31:0] err_addr = '0;
    logic [NL-1:0] dev_req = '0;
    logic        ack_valid = 1'b0;
    logic [1:0]  ack_level = '0;
    logic        ack_resp;
    logic [13:0] ack_vec;
    logic [NL-1:0] irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef enum int {K_IRQ, K_ACK, K_RD} kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    err_irq_ctrl #(.NL(NL), .AW(32)) u_err_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .err_event(err_event), .err_addr(err_addr), .dev_req(dev_req),
        .ack_valid(ack_valid), .ack_level(ack_level), .ack_resp(ack_resp),
        .ack_vec(ack_vec), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare every pending expectation at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_IRQ:   act = 32'(irq);
                K_ACK:   act = {17'b0, ack_resp, ack_vec};
                default: act = rd_data;
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h",
                         it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic exp_irq(input logic [NL-1:0] v, input string tag);
        sb_q.push_back('{K_IRQ, 32'(v), tag});
    endtask

    task automatic exp_ack(input logic [13:0] v, input string tag);
        sb_q.push_back('{K_ACK, {17'b0, 1'b1, v}, tag});
    endtask

    task automatic exp_rd(input logic [2:0] s, input logic [31:0] v, input string tag);
        rd_sel = s;
        sb_q.push_back('{K_RD, v, tag});
        tick();
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic ev(input logic [31:0] a);
        err_event = 1'b1; err_addr = a;
        tick();
        err_event = 1'b0;
    endtask

    task automatic ack(input logic [1:0] l);
        ack_valid = 1'b1; ack_level = l;
        tick();
        ack_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Driver: scenario sequence.
    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        exp_irq(4'h0, "R1");
        exp_rd(3'd0, 32'h0, "R1");
        exp_rd(3'd2, 32'h0, "R1");
        exp_rd(3'd4, 32'h0, "R1");
        exp_rd(3'd1, 32'h0, "R1");
        // setup: offset vector, enable + hard, vector 0x155, mask levels 0 and 2
        wr(3'd3, 32'h2AA);
        wr(3'd0, 32'h3);
        wr(3'd2, 32'h0005_0155);
        exp_irq(4'h0, "R4 no source");
        exp_rd(3'd3, 32'h2AA, "R6 voff");
        // R2 first error raises the interrupt
        ev(32'hDEAD_0000);
        exp_irq(4'b0101, "R2");
        exp_rd(3'd0, 32'h303, "R2");
        exp_rd(3'd2, 32'h8005_0155, "R2");
        exp_rd(3'd4, 32'hDEAD_0000, "R2");
        // R3 second error keeps the first address
        ev(32'h0000_1234);
        exp_rd(3'd4, 32'hDEAD_0000, "R3");
        // R6 acknowledge at unmasked level gives offset vector
        ack(2'd1);
        exp_ack(14'h2AA, "R6 miss");
        exp_irq(4'b0101, "R6 miss");
        // R6 acknowledge at masked level gives control vector, sets done
        ack(2'd2);
        exp_ack(14'h155, "R6 hit");
        exp_irq(4'h0, "R6 hit");
        exp_rd(3'd2, 32'hC005_0155, "R6 hit");
        // R5 downstream request merge
        dev_req = 4'b1000;
        tick();
        exp_irq(4'b1000, "R5");
        dev_req = 4'b0000;
        tick();
        exp_irq(4'h0, "R5");
        // R8 control write with enable clear drops the flag, force keeps done
        wr(3'd0, 32'h2);
        exp_rd(3'd0, 32'h102, "R8");
        exp_rd(3'd2, 32'hC005_0155, "R8");
        exp_rd(3'd1, 32'h1, "R8");
        wr(3'd1, 32'h1);
        exp_rd(3'd1, 32'h0, "R8");
        // R7 clearing done while force stays re-requests
        wr(3'd2, 32'hC005_0155);
        exp_irq(4'b0101, "R7");
        exp_rd(3'd2, 32'h8005_0155, "R7");
        // R4 enable gating: none, then soft only
        wr(3'd0, 32'h0);
        exp_irq(4'h0, "R4 gated");
        wr(3'd0, 32'h4);
        exp_irq(4'b0101, "R4 soft");
        exp_rd(3'd0, 32'h104, "R4 soft");
        // R9 write and acknowledge in one cycle: write is seen first
        wr_en = 1'b1; wr_sel = 3'd2; wr_data = 32'h8002_0155;
        ack_valid = 1'b1; ack_level = 2'd1;
        tick();
        wr_en = 1'b0; ack_valid = 1'b0;
        exp_ack(14'h155, "R9");
        exp_irq(4'h0, "R9");
        exp_rd(3'd2, 32'hC002_0155, "R9");
        // R7 force clear removes done
        wr(3'd2, 32'h0002_0155);
        exp_rd(3'd2, 32'h0002_0155, "R7");
        exp_irq(4'h0, "R7");
        // R10 clear fail flag and re-arm
        wr(3'd0, 32'h105);
        exp_rd(3'd0, 32'h005, "R10");
        ev(32'h0000_0BAD);
        exp_irq(4'b0010, "R10");
        exp_rd(3'd4, 32'h0000_0BAD, "R10");
        exp_rd(3'd0, 32'h305, "R10");
        // R2 event with interrupts disabled records but does not raise
        wr(3'd2, 32'h0002_0155);
        exp_irq(4'h0, "R7");
        wr(3'd0, 32'h104);
        ev(32'h0000_0077);
        exp_irq(4'h0, "R2 disabled");
        exp_rd(3'd4, 32'h0000_0077, "R2 disabled");
        exp_rd(3'd0, 32'h104, "R2 disabled");
        exp_rd(3'd2, 32'h0002_0155, "R2 disabled");
        tick();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule